// File: doc/BRIEF.md
# Memory Region Security Checker

This block screens every bus access that falls into two guarded address spaces, a flash space and a RAM space, against a per-space table of equal-sized regions. Each region holds read, write and execute permission bits, a secure attribute and a lock bit. One non-secure-callable window per space can be placed at the top of a chosen region. A secure master may then leave a region secure while still letting non-secure code fetch entry stubs from that window.

Configuration arrives on a simple single-cycle register write port. An access to be screened is presented on the check port as an address, an access kind and a secure flag. One cycle later the block returns a registered allow/deny verdict. Any denial inside a space sets that space's sticky violation flag. A shared interrupt line is raised while any flag whose enable bit is set remains high. Accesses outside both spaces are not screened.

Top module: `mem_region_guard`

## Requirements
- R1: A region's permission bits are independent: wr_data bit 0 grants read (kind 2'b00), bit 1 grants write (kind 2'b01) and bit 2 grants fetch (kind 2'b10). A secure access to any region, or any access to a non-secure region, is allowed exactly when the bit for its kind is set.
- R2: Region data bit 3 marks the region secure. A non-secure access to a secure region is denied unless R5 allows it, even when the permission bit is set.
- R3: Region data bit 4 locks the region. Once it is set, every later write to that region is ignored until reset, and an ignored write raises no event.
- R4: The window size field (wr_data[7:4] of a window write) selects a window of 16 << code bytes for codes 1 to 8 (32 to 4096 bytes). Code 0 and codes 9 to 15 disable the window.
- R5: A window write sets the region number (wr_data[2:0]), the size and a lock bit (wr_data[8]). The window occupies the top bytes of that region. A non-secure fetch inside an enabled window of a secure region with fetch permission is allowed, and every other non-secure access there is denied. A locked window ignores later writes until reset.
- R6: The flash space starts at FLASH_BASE and the RAM space at RAM_BASE. Each space holds 8 regions of 4 KiB, and the region index is bits [14:12] of (address - base). Addresses outside both spaces are always allowed and raise no event.
- R7: A denied access sets evt_flash or evt_ram for its space. A flag stays set until a write to address 20 with mask bit 0 (flash) or bit 1 (RAM) set. A violation in the same cycle as a clear leaves the flag set.
- R8: A write to address 18 sets the interrupt enable bits given by the mask, and a write to address 19 clears them, using the mask bits of R7. irq is high while any flag whose enable bit is set is high.
- R9: resp_valid follows chk_valid one cycle later and carries the verdict in resp_allow. resp_allow is 0 whenever resp_valid is 0. Kind 2'b11 is denied inside both spaces.
- R10: Write addresses 0-7 configure flash regions 0-7, 8-15 configure RAM regions 0-7, 16 is the flash window and 17 is the RAM window. After reset every region is secure with all permissions and no lock, both windows are disabled, and all flags and enables are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration write address |
| wr_data | input | 9 | Configuration write data |
| chk_valid | input | 1 | Access to screen is present |
| chk_addr | input | 32 | Address of the access |
| chk_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 invalid |
| chk_secure | input | 1 | Access carries the secure attribute |
| resp_valid | output | 1 | Verdict present (one cycle after chk_valid) |
| resp_allow | output | 1 | Access allowed |
| evt_flash | output | 1 | Sticky flash-space violation flag |
| evt_ram | output | 1 | Sticky RAM-space violation flag |
| irq | output | 1 | Any enabled violation flag is set |

## Verification
The hardest situation to reach from the ports is a non-secure fetch exactly at the lower edge of a window. The region must be secure, carry fetch permission, be named by the window entry and have a window of matching size, all at once. The bench therefore configures a secure fetch-only region directly and moves the window through several size codes, probing the first word inside and the last word outside each window. It then locks the window and shows that a later rewrite has no effect on a fetch verdict. A violation that arrives in the same cycle as a clear of its flag, and writes to locked entries, are driven on purpose. A seeded random mix of writes and accesses then runs against the behavioural model.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

  localparam int WDATA_W       = 9;
  localparam int NSC_SIZE_W    = 4;
  localparam int NSC_MAX_CODE  = 8;
  localparam int NSC_MIN_SHIFT = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic lock;
    logic sec;
    logic x;
    logic w;
    logic r;
  } region_cfg_t;

  localparam int CFG_W = $bits(region_cfg_t);
  localparam region_cfg_t CFG_RESET = '{lock: 1'b0, sec: 1'b1, x: 1'b1, w: 1'b1, r: 1'b1};

  function automatic logic perm_ok(region_cfg_t c, acc_kind_e k);
    case (k)
      ACC_READ:  return c.r;
      ACC_WRITE: return c.w;
      ACC_FETCH: return c.x;
      default:   return 1'b0;
    endcase
  endfunction

  // True when an offset inside a region lies in the top window of the given size code.
  function automatic logic in_window(logic [31:0] off, int rbits, logic [NSC_SIZE_W-1:0] code);
    logic [32:0] span;
    logic [32:0] size;
    if (code == '0 || int'(code) > NSC_MAX_CODE) return 1'b0;
    size = 33'd1 << (int'(code) + NSC_MIN_SHIFT);
    span = 33'd1 << rbits;
    if (size > span) return 1'b0;
    return {1'b0, off} >= (span - size);
  endfunction

  function automatic logic decide(region_cfg_t c, logic win, acc_kind_e k, logic secure);
    logic p;
    p = perm_ok(c, k);
    if (secure || !c.sec) return p;
    return win && (k == ACC_FETCH) && p;
  endfunction

endpackage

// File: rtl/mrg_wr_decode.sv
module mrg_wr_decode #(
  parameter int REGIONS = 8,
  parameter int WA_W    = 5,
  parameter int IDX_W   = 3
) (
  input  logic             wr_en,
  input  logic [WA_W-1:0]  wr_addr,
  output logic [1:0]       region_we,
  output logic [IDX_W-1:0] region_idx,
  output logic [1:0]       nsc_we,
  output logic             en_set,
  output logic             en_clr,
  output logic             ev_clr
);
  localparam logic [WA_W-1:0] A_RAM0  = WA_W'(REGIONS);
  localparam logic [WA_W-1:0] A_NSC_F = WA_W'(2 * REGIONS);
  localparam logic [WA_W-1:0] A_NSC_R = WA_W'(2 * REGIONS + 1);
  localparam logic [WA_W-1:0] A_ENSET = WA_W'(2 * REGIONS + 2);
  localparam logic [WA_W-1:0] A_ENCLR = WA_W'(2 * REGIONS + 3);
  localparam logic [WA_W-1:0] A_EVCLR = WA_W'(2 * REGIONS + 4);

  logic [WA_W-1:0] rel;
  assign rel = wr_addr - A_RAM0;

  always_comb begin
    region_we  = 2'b00;
    region_idx = wr_addr[IDX_W-1:0];
    nsc_we     = 2'b00;
    en_set     = 1'b0;
    en_clr     = 1'b0;
    ev_clr     = 1'b0;
    if (wr_en) begin
      if (wr_addr < A_RAM0) begin
        region_we[0] = 1'b1;
      end else if (wr_addr < A_NSC_F) begin
        region_we[1] = 1'b1;
        region_idx   = rel[IDX_W-1:0];
      end else begin
        nsc_we[0] = (wr_addr == A_NSC_F);
        nsc_we[1] = (wr_addr == A_NSC_R);
        en_set    = (wr_addr == A_ENSET);
        en_clr    = (wr_addr == A_ENCLR);
        ev_clr    = (wr_addr == A_EVCLR);
      end
    end
  end
endmodule

// File: rtl/mrg_space_table.sv
module mrg_space_table
  import mrg_pkg::*;
#(
  parameter int               REGIONS     = 8,
  parameter int               REGION_BITS = 12,
  parameter int               ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE       = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [$clog2(REGIONS)-1:0] cfg_idx,
  input  region_cfg_t            cfg_wdata,
  input  logic                   nsc_we,
  input  logic [$clog2(REGIONS)-1:0] nsc_region_in,
  input  logic [NSC_SIZE_W-1:0]  nsc_size_in,
  input  logic                   nsc_lock_in,
  input  logic [ADDR_W-1:0]      look_addr,
  output logic                   in_space,
  output region_cfg_t            look_cfg,
  output logic                   look_win
);
  localparam int IDX_W = $clog2(REGIONS);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(REGIONS) << REGION_BITS;

  region_cfg_t            cfg_q [REGIONS];
  logic [IDX_W-1:0]       nsc_region_q;
  logic [NSC_SIZE_W-1:0]  nsc_size_q;
  logic                   nsc_lock_q;

  genvar gi;
  generate
    for (gi = 0; gi < REGIONS; gi++) begin : g_region
      always_ff @(posedge clk) begin
        if (rst) begin
          cfg_q[gi] <= CFG_RESET;
        end else if (cfg_we && (cfg_idx == IDX_W'(gi)) && !cfg_q[gi].lock) begin
          cfg_q[gi] <= cfg_wdata;
        end
      end

      // R3: a locked region keeps its whole configuration
      a_r3_lock_holds: assert property (@(posedge clk) disable iff (rst)
        cfg_q[gi].lock |=> $stable(cfg_q[gi]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      nsc_region_q <= '0;
      nsc_size_q   <= '0;
      nsc_lock_q   <= 1'b0;
    end else if (nsc_we && !nsc_lock_q) begin
      nsc_region_q <= nsc_region_in;
      nsc_size_q   <= nsc_size_in;
      nsc_lock_q   <= nsc_lock_in;
    end
  end

  // R5: a locked window entry never changes until reset
  a_r5_nsc_lock_holds: assert property (@(posedge clk) disable iff (rst)
    nsc_lock_q |=> (nsc_lock_q && $stable(nsc_region_q) && $stable(nsc_size_q)));

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;

  assign off      = look_addr - BASE;
  assign in_space = ({1'b0, off} < SPAN);
  assign idx      = off[REGION_BITS +: IDX_W];
  assign look_cfg = cfg_q[idx];
  assign look_win = (nsc_region_q == idx) &&
                    in_window(32'(off[REGION_BITS-1:0]), REGION_BITS, nsc_size_q);
endmodule

// File: rtl/mrg_event_unit.sv
module mrg_event_unit #(
  parameter int SPACES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SPACES-1:0] viol,
  input  logic [SPACES-1:0] mask,
  input  logic              ev_clr,
  input  logic              en_set,
  input  logic              en_clr,
  output logic [SPACES-1:0] evt_q,
  output logic [SPACES-1:0] en_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      en_q  <= '0;
    end else begin
      evt_q <= viol | (evt_q & ~(ev_clr ? mask : '0));
      if (en_set)      en_q <= en_q | mask;
      else if (en_clr) en_q <= en_q & ~mask;
    end
  end

  assign irq = |(evt_q & en_q);

  genvar gs;
  generate
    for (gs = 0; gs < SPACES; gs++) begin : g_chk
      // R7: a flag only drops through an explicit clear
      a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (evt_q[gs] && !(ev_clr && mask[gs])) |=> evt_q[gs]);
      // R7: a violation always lands in its flag, even against a clear
      a_r7_viol_sets: assert property (@(posedge clk) disable iff (rst)
        viol[gs] |=> evt_q[gs]);
      // R8: enable set takes effect on the next cycle
      a_r8_enable_set: assert property (@(posedge clk) disable iff (rst)
        (en_set && mask[gs]) |=> en_q[gs]);
    end
  endgenerate
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
  import mrg_pkg::*;
#(
  parameter int                REGIONS     = 8,
  parameter int                REGION_BITS = 12,
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] RAM_BASE    = 32'h2000_0000
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [$clog2(2*REGIONS+5)-1:0]     wr_addr,
  input  logic [8:0]                         wr_data,
  input  logic                               chk_valid,
  input  logic [ADDR_W-1:0]                  chk_addr,
  input  logic [1:0]                         chk_kind,
  input  logic                               chk_secure,
  output logic                               resp_valid,
  output logic                               resp_allow,
  output logic                               evt_flash,
  output logic                               evt_ram,
  output logic                               irq
);
  localparam int IDX_W  = $clog2(REGIONS);
  localparam int WA_W   = $clog2(2*REGIONS+5);
  localparam int SPACES = 2;

  logic [SPACES-1:0] region_we;
  logic [IDX_W-1:0]  region_idx;
  logic [SPACES-1:0] nsc_we;
  logic              en_set, en_clr, ev_clr;

  mrg_wr_decode #(.REGIONS(REGIONS), .WA_W(WA_W), .IDX_W(IDX_W)) u_dec (
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .region_we  (region_we),
    .region_idx (region_idx),
    .nsc_we     (nsc_we),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .ev_clr     (ev_clr)
  );

  region_cfg_t       look_cfg [SPACES];
  logic [SPACES-1:0] in_sp;
  logic [SPACES-1:0] look_win;

  genvar gs;
  generate
    for (gs = 0; gs < SPACES; gs++) begin : g_space
      localparam logic [ADDR_W-1:0] SBASE = (gs == 0) ? FLASH_BASE : RAM_BASE;
      mrg_space_table #(
        .REGIONS(REGIONS), .REGION_BITS(REGION_BITS), .ADDR_W(ADDR_W), .BASE(SBASE)
      ) u_tab (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (region_we[gs]),
        .cfg_idx       (region_idx),
        .cfg_wdata     (region_cfg_t'(wr_data[CFG_W-1:0])),
        .nsc_we        (nsc_we[gs]),
        .nsc_region_in (wr_data[IDX_W-1:0]),
        .nsc_size_in   (wr_data[7:4]),
        .nsc_lock_in   (wr_data[8]),
        .look_addr     (chk_addr),
        .in_space      (in_sp[gs]),
        .look_cfg      (look_cfg[gs]),
        .look_win      (look_win[gs])
      );
    end
  endgenerate

  acc_kind_e         kind;
  logic              allow_d;
  logic [SPACES-1:0] hit;
  logic [SPACES-1:0] viol;

  assign kind = acc_kind_e'(chk_kind);

  always_comb begin
    allow_d = 1'b1;
    hit     = '0;
    if (in_sp[0]) begin
      hit[0]  = 1'b1;
      allow_d = decide(look_cfg[0], look_win[0], kind, chk_secure);
    end else if (in_sp[1]) begin
      hit[1]  = 1'b1;
      allow_d = decide(look_cfg[1], look_win[1], kind, chk_secure);
    end
  end

  assign viol = (chk_valid && !allow_d) ? hit : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
    end else begin
      resp_valid <= chk_valid;
      resp_allow <= chk_valid && allow_d;
    end
  end

  logic [SPACES-1:0] evt_q;
  logic [SPACES-1:0] en_q;

  mrg_event_unit #(.SPACES(SPACES)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .viol   (viol),
    .mask   (wr_data[SPACES-1:0]),
    .ev_clr (ev_clr),
    .en_set (en_set),
    .en_clr (en_clr),
    .evt_q  (evt_q),
    .en_q   (en_q),
    .irq    (irq)
  );

  assign evt_flash = evt_q[0];
  assign evt_ram   = evt_q[1];

  // R9: a verdict appears exactly one cycle after each request
  a_r9_resp_follows: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> resp_valid);
  a_r9_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !resp_valid);
  a_r9_allow_needs_valid: assert property (@(posedge clk) disable iff (rst)
    resp_allow |-> resp_valid);
  // R7: every denial is reflected in some violation flag
  a_r7_deny_flags: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_allow) |-> (evt_flash || evt_ram));
  // R6: an access outside both spaces is never denied
  a_r6_outside_allowed: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && in_sp == '0) |=> resp_allow);
endmodule

// File: tb/tb_mem_region_guard.sv
module tb_mem_region_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [8:0]  wr_data = '0;
  logic        chk_valid = 1'b0;
  logic [31:0] chk_addr = '0;
  logic [1:0]  chk_kind = '0;
  logic        chk_secure = 1'b0;
  logic        resp_valid, resp_allow, evt_flash, evt_ram, irq;

  always #5 clk = ~clk;

  mem_region_guard dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_kind(chk_kind), .chk_secure(chk_secure),
    .resp_valid(resp_valid), .resp_allow(resp_allow), .evt_flash(evt_flash),
    .evt_ram(evt_ram), .irq(irq)
  );

  // behavioural reference model: index 0 = flash, 1 = RAM
  int m_cfg [2][8];
  int m_nreg [2];
  int m_ncode [2];
  bit m_nlock [2];
  bit m_ev [2];
  bit m_en [2];
  bit e_valid, e_allow;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  function automatic int space_of(bit [31:0] a, output longint off);
    longint la = longint'(a);
    off = 0;
    if (la < 32768) begin off = la; return 0; end
    if (la >= 64'h2000_0000 && la < 64'h2000_8000) begin off = la - 64'h2000_0000; return 1; end
    return -1;
  endfunction

  function automatic bit m_decide(int sp, longint off, int kind, bit sec);
    int  region = int'(off / 4096);
    int  inner  = int'(off % 4096);
    int  c      = m_cfg[sp][region];
    bit  perm;
    int  wsize;
    case (kind)
      0: perm = (c & 1) != 0;
      1: perm = (c & 2) != 0;
      2: perm = (c & 4) != 0;
      default: perm = 1'b0;
    endcase
    if (sec || (c & 8) == 0) return perm;
    if (m_ncode[sp] < 1 || m_ncode[sp] > 8) return 1'b0;
    if (m_nreg[sp] != region) return 1'b0;
    wsize = 16 << m_ncode[sp];
    return (inner >= 4096 - wsize) && kind == 2 && perm;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < 2; s++) begin
      for (int r = 0; r < 8; r++) m_cfg[s][r] = 15;
      m_nreg[s] = 0; m_ncode[s] = 0; m_nlock[s] = 0; m_ev[s] = 0; m_en[s] = 0;
    end
    e_valid = 0; e_allow = 0;
  endtask

  task automatic m_clock();
    bit     viol [2];
    longint off;
    int     sp;
    int     a = int'(wr_addr);
    int     d = int'(wr_data);
    viol[0] = 0; viol[1] = 0;
    e_valid = chk_valid;
    e_allow = 0;
    if (chk_valid) begin
      sp = space_of(chk_addr, off);
      if (sp < 0) e_allow = 1;
      else begin
        e_allow = m_decide(sp, off, int'(chk_kind), chk_secure);
        if (!e_allow) viol[sp] = 1;
      end
    end
    for (int s = 0; s < 2; s++) begin
      bit clr = wr_en && a == 20 && ((d >> s) & 1) != 0;
      m_ev[s] = viol[s] || (m_ev[s] && !clr);
    end
    if (wr_en) begin
      if (a < 16) begin
        if ((m_cfg[a / 8][a % 8] & 16) == 0) m_cfg[a / 8][a % 8] = d & 31;
      end else if (a == 16 || a == 17) begin
        if (!m_nlock[a - 16]) begin
          m_nreg[a - 16]  = d & 7;
          m_ncode[a - 16] = (d >> 4) & 15;
          m_nlock[a - 16] = ((d >> 8) & 1) != 0;
        end
      end else if (a == 18) begin
        for (int s = 0; s < 2; s++) if (((d >> s) & 1) != 0) m_en[s] = 1;
      end else if (a == 19) begin
        for (int s = 0; s < 2; s++) if (((d >> s) & 1) != 0) m_en[s] = 0;
      end
    end
  endtask

  task automatic compare(string tag);
    bit [4:0] act, exp;
    act = {resp_valid, resp_allow, evt_flash, evt_ram, irq};
    exp = {e_valid, e_allow, m_ev[0], m_ev[1], (m_ev[0] && m_en[0]) || (m_ev[1] && m_en[1])};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,allow,evf,evr,irq} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one clock: inputs already set at the falling edge
  task automatic step(string tag);
    @(posedge clk);
    if (rst) m_reset(); else m_clock();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    wr_en = 0; chk_valid = 0;
    step(tag);
  endtask

  task automatic wr(int a, int d, string tag);
    wr_en = 1; wr_addr = 5'(a); wr_data = 9'(d); chk_valid = 0;
    step(tag);
    wr_en = 0;
  endtask

  task automatic chk(bit [31:0] a, int kind, bit sec, bit exp_allow, string tag);
    wr_en = 0; chk_valid = 1; chk_addr = a; chk_kind = 2'(kind); chk_secure = sec;
    step(tag);
    chk_valid = 0;
    vectors++;
    if (resp_allow !== exp_allow) begin
      errors++;
      $display("FAIL %s: resp_allow actual=%b expected=%b addr=%h", tag, resp_allow, exp_allow, a);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    rst = 1;
    step("R10 reset");
    step("R10 reset");
    rst = 0;
    idle("R10 idle after reset");

    // reset state: secure rwx regions
    chk(32'h2000_0000, 0, 1, 1, "R10 secure read after reset");
    chk(32'h2000_0010, 0, 0, 0, "R2 non-secure read of secure region");

    // interrupt enables (mask bit1 = RAM)
    wr(18, 2, "R8 enable RAM irq");
    wr(20, 2, "R7 clear RAM flag");
    wr(19, 2, "R8 disable RAM irq");
    chk(32'h2000_0020, 1, 0, 0, "R8 deny with irq disabled");

    // permission combinations, flash region 2
    wr(2, 5'b00001, "R1 flash r2 non-secure read only");
    chk(32'h0000_2004, 0, 0, 1, "R1 read granted");
    chk(32'h0000_2004, 1, 0, 0, "R1 write refused");
    chk(32'h0000_2004, 2, 0, 0, "R1 fetch refused");
    chk(32'h0000_2004, 3, 0, 0, "R9 invalid kind denied");
    wr(2, 5'b00110, "R1 flash r2 write+fetch");
    chk(32'h0000_2100, 0, 0, 0, "R1 read refused");
    chk(32'h0000_2100, 1, 0, 1, "R1 write granted");
    chk(32'h0000_2100, 2, 0, 1, "R1 fetch granted");
    chk(32'h0000_2100, 0, 1, 0, "R1 secure read still needs perm");
    wr(20, 3, "R7 clear both flags");

    // region index decode
    wr(15, 5'b00111, "R6 ram r7 non-secure rwx");
    chk(32'h2000_7ABC, 0, 0, 1, "R6 index 7 selected");
    chk(32'h2000_6ABC, 0, 0, 0, "R6 index 6 still secure");
    chk(32'h0000_8000, 3, 0, 1, "R6 past flash span unscreened");
    chk(32'h4000_0000, 1, 0, 1, "R6 outside both spaces");

    // lock
    wr(11, 5'b10011, "R3 ram r3 rw non-secure locked");
    chk(32'h2000_3000, 0, 0, 1, "R3 locked region read");
    wr(11, 5'b01000, "R3 write to locked region");
    chk(32'h2000_3000, 0, 0, 1, "R3 lock kept old config");
    chk(32'h2000_3000, 2, 0, 0, "R3 fetch still refused");
    wr(20, 3, "R7 clear both flags");
    wr(11, 5'b01111, "R3 ignored write raises no event");

    // non-secure-callable window, flash region 5
    wr(5, 5'b01100, "R5 flash r5 secure fetch-only");
    wr(16, 9'h035, "R4 window r5 code 3 (128 B)");
    chk(32'h0000_5F80, 2, 0, 1, "R5 fetch at window start");
    chk(32'h0000_5F7C, 2, 0, 0, "R5 fetch just below window");
    chk(32'h0000_5FFC, 0, 0, 0, "R5 read in window denied");
    chk(32'h0000_5000, 2, 1, 1, "R2 secure fetch");
    chk(32'h0000_4FFC, 2, 0, 0, "R5 window bound to its region");
    wr(16, 9'h085, "R4 code 8 (4096 B)");
    chk(32'h0000_5000, 2, 0, 1, "R4 whole region window");
    wr(16, 9'h015, "R4 code 1 (32 B)");
    chk(32'h0000_5FE0, 2, 0, 1, "R4 32 B window start");
    chk(32'h0000_5FDC, 2, 0, 0, "R4 below 32 B window");
    wr(16, 9'h095, "R4 code 9 disabled");
    chk(32'h0000_5FFC, 2, 0, 0, "R4 code 9 gives no window");
    wr(16, 9'h005, "R4 code 0 disabled");
    chk(32'h0000_5FFC, 2, 0, 0, "R4 code 0 gives no window");
    wr(16, 9'h185, "R5 code 8 with lock");
    wr(16, 9'h005, "R5 write to locked window");
    chk(32'h0000_5000, 2, 0, 1, "R5 locked window unchanged");

    // violation racing a clear
    wr_en = 1; wr_addr = 5'd20; wr_data = 9'd1;
    chk_valid = 1; chk_addr = 32'h0000_0040; chk_kind = 2'd0; chk_secure = 0;
    step("R7 violation beats clear");
    wr_en = 0; chk_valid = 0;
    vectors++;
    if (evt_flash !== 1'b1) begin
      errors++;
      $display("FAIL R7 set-wins: evt_flash actual=%b expected=1", evt_flash);
    end
    wr(18, 1, "R8 enable flash irq");
    vectors++;
    if (irq !== 1'b1) begin
      errors++;
      $display("FAIL R8 irq: actual=%b expected=1", irq);
    end
    idle("R9 idle gives no response");

    // seeded random mix against the model
    rst = 1;
    step("R10 reset again");
    rst = 0;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 600; i++) begin
      int pick = int'($urandom_range(0, 9));
      wr_en = (pick < 3);
      wr_addr = 5'($urandom_range(0, 21));
      wr_data = 9'($urandom);
      if ($urandom_range(0, 3) == 0) wr_data[8] = 1'b0;
      if (wr_addr < 16 && $urandom_range(0, 2) != 0) wr_data[4] = 1'b0;
      chk_valid = (pick >= 2);
      case ($urandom_range(0, 4))
        0, 1: chk_addr = 32'($urandom_range(0, 32'h7FFF));
        2, 3: chk_addr = 32'h2000_0000 + 32'($urandom_range(0, 32'h7FFF));
        default: chk_addr = 32'h2000_8000 + 32'($urandom_range(0, 255));
      endcase
      if ($urandom_range(0, 1) == 0) chk_addr[11:0] = 12'hFFF - 12'($urandom_range(0, 300));
      chk_kind = 2'($urandom);
      chk_secure = ($urandom_range(0, 3) == 0);
      step("R9 random mix R1 R2 R5 R7");
    end
    wr_en = 0; chk_valid = 0;
    idle("R9 final idle");
    finish_run();
  end

endmodule